// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block supplies the word address for every beat of a four-beat memory burst. A load cycle captures a complete external address. Each following advance cycle steps only the two least significant bits, while the upper bits stay at the value captured at load. A static order input chooses how the two low bits step. When it is high, the low bits are the start value XOR a beat count. When it is low, they are the start value plus the beat count, wrapping inside four.

An active-low clock enable gates every register, so a burst can be stalled for any number of cycles and resumed where it stopped. The output address and a one-cycle load strobe are both registered. The address reflects the command sampled at the previous rising edge. Chip-select decoding, the data path and the storage array belong to neighbouring blocks.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block clears its state; after that edge `addr_out` is 0 and `load_stb` is 0.
- R2: An enabled edge (`clk_en_n` = 0) with `load_n` = 0 captures `addr_in`; after that edge `addr_out` equals the captured address and `load_stb` is 1.
- R3: An enabled edge with `load_n` = 1 is an advance: `addr_in` has no effect on the output, and `load_stb` is 0 after that edge.
- R4: With `order_sel` = 1 (the level an undriven or tied-high mode input presents), the low two bits after the k-th advance are the start value XOR k. Start 2 gives 2, 3, 0, 1.
- R5: With `order_sel` = 0, the low two bits after the k-th advance are the start value plus k, modulo 4. Start 1 gives 1, 2, 3, 0.
- R6: Bits above bit 1 of `addr_out` never change on an advance. A wrap of the low bits from 3 to 0 does not carry into them.
- R7: An edge with `clk_en_n` = 1 changes nothing: `addr_out` and `load_stb` keep their values whatever `load_n` and `addr_in` are. A burst that was stalled this way resumes in the step where it stopped.
- R8: Advances after the fourth beat keep cycling in the same order. The fifth beat repeats the start address, until a new load occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en_n | input | 1 | Clock enable, active low; high freezes all state |
| load_n | input | 1 | Low: load a new address; high: advance the burst |
| order_sel | input | 1 | Burst order: 1 interleaved (XOR), 0 linear (wrapping add) |
| addr_in | input | 19 | External word address, used only on load |
| addr_out | output | 19 | Address of the current beat |
| load_stb | output | 1 | High for the beat that follows an accepted load |

## Verification
The embedded properties check the following on every cycle: that a load shows the captured address and raises the strobe, that an advance keeps the upper bits and drops the strobe, that a disabled edge leaves the outputs still, and that the linear order steps by exactly one. The interleaved order cannot be judged from one cycle to the next without knowing the start value. It is therefore shown only by the bench's scenarios, which walk full bursts in both orders. Those scenarios also cover the wrap past the fourth beat, the no-carry case with all upper bits set, and the resumption of a stalled burst.

// File: rtl/burst_seq_pkg.sv
// Package: shared types for the burst address sequencer.
// Assumes: the order select is a single static level.
package burst_seq_pkg;

    typedef enum logic {
        ORD_LINEAR      = 1'b0,
        ORD_INTERLEAVED = 1'b1
    } burst_order_e;

endpackage

// File: rtl/burst_beat_ctr.sv
// Module: burst_beat_ctr
// Counts the beats of a burst. It clears on an accepted load and adds one on each
// accepted advance, wrapping at its own width. Assumes clear and step are never high together.
module burst_beat_ctr #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_en,
    input  logic             step_en,
    output logic [CNT_W-1:0] beat
);

    // Purpose: beat register, with reset, clear on load, step on advance, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat <= '0;
        end else if (clear_en) begin
            beat <= '0;
        end else if (step_en) begin
            beat <= beat + 1'b1;
        end
    end

    a_r2_beat_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clear_en |=> (beat == '0));

    a_r7_beat_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_en && !step_en) |=> $stable(beat));

endmodule

// File: rtl/burst_base_reg.sv
// Module: burst_base_reg
// Holds the start address of the current burst. It is loaded only when capture is high.
// Assumes the capture input is already qualified by the clock enable.
module burst_base_reg #(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] base
);

    // Purpose: capture the external address on load, otherwise keep it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base <= '0;
        end else if (cap_en) begin
            base <= addr_in;
        end
    end

    a_r3_base_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(base));

endmodule

// File: rtl/burst_low_map.sv
// Module: burst_low_map
// Combines the start value of the low bits with the beat count in the order selected.
// Interleaved order XORs them; linear order adds them, wrapping at LOW_W bits.
// Assumes order_sel does not change in the middle of a burst.
module burst_low_map
    import burst_seq_pkg::*;
#(
    parameter int LOW_W = 2
) (
    input  logic [LOW_W-1:0] start_lo,
    input  logic [LOW_W-1:0] beat,
    input  logic             order_sel,
    output logic [LOW_W-1:0] low
);

    logic [LOW_W-1:0] lo_xor;
    logic [LOW_W-1:0] lo_add;

    // Purpose: build the interleaved candidate one bit at a time.
    for (genvar g = 0; g < LOW_W; g++) begin : g_xor_bit
        assign lo_xor[g] = start_lo[g] ^ beat[g];
    end

    // Purpose: build the linear candidate; the sum is truncated so it wraps inside the burst.
    assign lo_add = start_lo + beat;

    // Purpose: choose the candidate that matches the burst order.
    always_comb begin
        unique case (burst_order_e'(order_sel))
            ORD_INTERLEAVED: low = lo_xor;
            ORD_LINEAR:      low = lo_add;
            default:         low = lo_xor;
        endcase
    end

endmodule

// File: rtl/burst_addr_seq.sv
// Module: burst_addr_seq (top)
// Produces the word address of each beat of a burst of 2**LOW_W beats. A load
// captures the full address; advances step only the LOW_W low bits in either
// interleaved or linear order. Assumes order_sel is static during a burst and
// that reset is synchronous and active low.
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int LOW_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en_n,
    input  logic              load_n,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic              load_stb
);

    localparam int HI_W = ADDR_W - LOW_W;

    logic              fire;
    logic              cap;
    logic              adv;
    logic [ADDR_W-1:0] base;
    logic [LOW_W-1:0]  beat;
    logic [LOW_W-1:0]  low;

    // Purpose: qualify the load and advance commands with the clock enable.
    assign fire = !clk_en_n;
    assign cap  = fire && !load_n;
    assign adv  = fire && load_n;

    burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_en  (cap),
        .addr_in (addr_in),
        .base    (base)
    );

    burst_beat_ctr #(.CNT_W(LOW_W)) u_beat (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_en (cap),
        .step_en  (adv),
        .beat     (beat)
    );

    burst_low_map #(.LOW_W(LOW_W)) u_map (
        .start_lo  (base[LOW_W-1:0]),
        .beat      (beat),
        .order_sel (order_sel),
        .low       (low)
    );

    // Purpose: put the fixed upper part next to the sequenced low part.
    assign addr_out = {base[ADDR_W-1:LOW_W], low};

    // Purpose: load strobe, set for the beat after an accepted load, frozen while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_stb <= 1'b0;
        end else if (fire) begin
            load_stb <= !load_n;
        end
    end

    a_r2_load_shows_addr: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> (addr_out == $past(addr_in)) && load_stb);

    a_r3_stb_low_on_adv: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> !load_stb);

    a_r6_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (addr_out[ADDR_W-1:LOW_W] == $past(addr_out[ADDR_W-1:LOW_W])));

    a_r5_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && (order_sel == ORD_LINEAR)) |=>
            (order_sel != ORD_LINEAR) ||
            (addr_out[LOW_W-1:0] == LOW_W'($past(addr_out[LOW_W-1:0]) + 1'b1)));

    a_r7_outputs_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> !$stable(order_sel) || ($stable(addr_out) && $stable(load_stb)));

    initial begin
        a_r6_width_ok: assert (HI_W > 0);
    end

endmodule

// File: tb/test_burst_addr_seq.sv
`timescale 1ns/1ps
module test_burst_addr_seq;

    localparam int AW = 19;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          clk_en_n;
    logic          load_n;
    logic          order_sel;
    logic [AW-1:0] addr_in;
    logic [AW-1:0] addr_out;
    logic          load_stb;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW), .LOW_W(2)) i_burst_addr_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en_n  (clk_en_n),
        .load_n    (load_n),
        .order_sel (order_sel),
        .addr_in   (addr_in),
        .addr_out  (addr_out),
        .load_stb  (load_stb)
    );

    // Expected address after k advances from start s in the given order.
    function automatic logic [AW-1:0] expect_addr(input logic [AW-1:0] s, input int k,
                                                  input logic inter);
        logic [1:0] kk;
        logic [1:0] lo;
        kk = 2'(k % 4);
        if (inter) lo = s[1:0] ^ kk;
        else       lo = 2'((int'(s[1:0]) + k) % 4);
        return {s[AW-1:2], lo};
    endfunction

    task automatic check(input bit ok, input string req, input logic [AW-1:0] act,
                         input logic [AW-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle at a falling edge; outputs are valid at the next falling edge.
    task automatic cyc(input logic ld_n, input logic en_n, input logic [AW-1:0] a);
        load_n   = ld_n;
        clk_en_n = en_n;
        addr_in  = a;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        cyc(1'b0, 1'b0, 19'h7ABCD);
        cyc(1'b0, 1'b0, 19'h7ABCD);
        check(addr_out == '0, "R1 addr", addr_out, '0);
        check(load_stb == 1'b0, "R1 stb", AW'(load_stb), '0);
        rst_n = 1'b1;
    endtask

    // Load then walk a burst, feeding junk on addr_in during advances.
    task automatic t_burst(input logic [AW-1:0] s, input logic inter, input string tag);
        order_sel = inter;
        cyc(1'b0, 1'b0, s);
        check(addr_out == s, "R2 load addr", addr_out, s);
        check(load_stb == 1'b1, "R2 stb", AW'(load_stb), 19'd1);
        for (int k = 1; k <= 5; k++) begin
            cyc(1'b1, 1'b0, ~s ^ AW'(k * 37));
            check(addr_out == expect_addr(s, k, inter), tag, addr_out, expect_addr(s, k, inter));
            check(addr_out[AW-1:2] == s[AW-1:2], "R6 upper", addr_out, s);
            check(load_stb == 1'b0, "R3 stb", AW'(load_stb), '0);
        end
        check(addr_out == expect_addr(s, 1, inter), "R8 wrap repeats", addr_out,
              expect_addr(s, 1, inter));
    endtask

    task automatic t_no_carry();
        order_sel = 1'b0;
        cyc(1'b0, 1'b0, 19'h7FFFF);
        cyc(1'b1, 1'b0, 19'h00000);
        check(addr_out == 19'h7FFFC, "R6 no carry", addr_out, 19'h7FFFC);
    endtask

    task automatic t_hold();
        logic [AW-1:0] s;
        s = 19'h2C3D2;
        order_sel = 1'b1;
        cyc(1'b0, 1'b0, s);
        cyc(1'b1, 1'b0, 19'h0);
        for (int i = 0; i < 3; i++) begin
            cyc(1'b0, 1'b1, 19'h15555 + AW'(i));
            check(addr_out == expect_addr(s, 1, 1'b1), "R7 hold addr", addr_out,
                  expect_addr(s, 1, 1'b1));
            check(load_stb == 1'b0, "R7 hold stb", AW'(load_stb), '0);
        end
        cyc(1'b1, 1'b0, 19'h0);
        check(addr_out == expect_addr(s, 2, 1'b1), "R7 resume", addr_out,
              expect_addr(s, 2, 1'b1));
        // Stall right after a load: strobe must stay high.
        cyc(1'b0, 1'b0, 19'h01234);
        cyc(1'b1, 1'b1, 19'h0);
        check(load_stb == 1'b1, "R7 stb frozen", AW'(load_stb), 19'd1);
        check(addr_out == 19'h01234, "R7 addr frozen", addr_out, 19'h01234);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        rst_n = 1'b0; clk_en_n = 1'b0; load_n = 1'b1; order_sel = 1'b1; addr_in = '0;
        @(negedge clk);
        t_reset();
        t_burst(19'h5A5A6, 1'b1, "R4 interleaved");
        t_burst(19'h12345, 1'b0, "R5 linear");
        t_burst(19'h40003, 1'b1, "R4 interleaved s3");
        t_burst(19'h0F002, 1'b0, "R5 linear s2");
        t_no_carry();
        t_hold();
        finish_run();
    end

    initial begin
        #(200000 * 20);
        checks++;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

endmodule